// File: doc/BRIEF.md
# Converter Safety Trip Controller

This block stands between a converter controller and the gate drivers of the power switches. Every cycle it passes a requested gate vector through to the drivers. It also watches four kinds of hazard: over-current on the current channels, over-voltage on the voltage channels, a processor that has stopped running, and a lost link to the host computer. When any hazard appears, all gate outputs go inactive in the same cycle. The controller then stays tripped, with a one-hot record of the first hazard, until software asks for a clear while no hazard is still present.

The measurement words are unipolar ADC codes. Zero signal sits at mid-scale, so each channel is judged on its distance from mid-scale in either direction, against a per-channel limit supplied on register inputs. Two watchdogs count clock cycles since the last level change of their keep-alive input. The processor toggles one keep-alive as a heartbeat. The other toggles whenever a host message arrives. Each watchdog has its own programmable timeout.

Top module: `conv_trip_guard`

## Requirements
- R1: While rst_n is low, gate_out, fault_code and tripped are all zero, whatever gate_req holds.
- R2: While not tripped and no hazard is present, gate_out equals the gate_req value sampled at the previous rising edge.
- R3: Channels 0 to 3 carry current. A sample taken with smp_valid high whose distance from code 2048 is greater than that channel's lim_cur field trips the block with fault_code 4'b0001 two edges after it is presented. A distance equal to the limit does not trip.
- R4: Channels 4 to 7 carry voltage. A distance from 2048 greater than that channel's lim_volt field trips the block with fault_code 4'b0010.
- R5: Sample words presented while smp_valid is low have no effect on the outputs.
- R6: If cpu_beat holds its level, tripped stays low for cpu_timeout+1 rising edges after its last change and rises on the next one, with fault_code 4'b0100. Any level change restarts the count.
- R7: host_alive works in the same way with host_timeout and fault_code 4'b1000.
- R8: In the cycle that tripped rises, all 12 bits of gate_out are zero together. They stay zero while tripped, whatever gate_req does.
- R9: fault_code keeps the first cause until a clear is taken, and later causes leave it unchanged. Causes that arrive in the same cycle record only the lowest-numbered bit (over-current before over-voltage before processor before host).
- R10: clear_req clears tripped and fault_code on the next edge only when no hazard is present. A channel hazard stays present until a valid in-limit sample replaces it. A watchdog hazard stays present until its keep-alive changes level. Otherwise the request is ignored.
- R11: Deviations below mid-scale are judged like those above it: code 2048-L-1 trips a channel whose limit is L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data | input | 96 | Eight 12-bit samples, channel i at bits [12i+11:12i] |
| smp_valid | input | 1 | Samples are a fresh conversion |
| lim_cur | input | 48 | Deviation limits for channels 0 to 3 |
| lim_volt | input | 48 | Deviation limits for channels 4 to 7 |
| cpu_beat | input | 1 | Processor heartbeat, toggled by software |
| host_alive | input | 1 | Toggled on each host message |
| cpu_timeout | input | 24 | Processor watchdog timeout in clock cycles |
| host_timeout | input | 24 | Host watchdog timeout in clock cycles |
| gate_req | input | 12 | Requested switch states |
| clear_req | input | 1 | Request to leave the tripped state |
| gate_out | output | 12 | Gate drive vector, zero when tripped |
| fault_code | output | 4 | One-hot first cause: bit0 current, bit1 voltage, bit2 processor, bit3 host |
| tripped | output | 1 | Block is in the shutdown state |

## Verification
The channel check is driven with a deviation exactly at the limit, one code beyond it above mid-scale, one code beyond it below mid-scale, and full-scale codes at both ends. These tell a strict comparison from an inclusive one and show whether the absolute-value step is symmetric. An out-of-limit word held with smp_valid low separates sampling on the valid strobe from continuous comparison. Causes are applied one after another and in the same cycle, which shows whether fault_code keeps the first cause and applies the right priority. The watchdogs are stopped at a known edge and checked one cycle before and at the expected trip, which pins down the count to within a cycle. Clear requests are issued both while a hazard persists and after it has gone, to show that a clear only takes effect once no hazard remains.

// File: rtl/trip_pkg.sv
package trip_pkg;

  // fault bit positions; the priority among simultaneous causes follows
  // these indices, lowest first
  localparam int unsigned FC_W    = 4;
  localparam int unsigned FC_CUR  = 0;
  localparam int unsigned FC_VOLT = 1;
  localparam int unsigned FC_CPU  = 2;
  localparam int unsigned FC_HOST = 3;

  // isolate the lowest set bit of a cause vector
  function automatic logic [FC_W-1:0] lowest_cause(input logic [FC_W-1:0] v);
    logic [FC_W-1:0] neg;
    neg = ~v + {{(FC_W-1){1'b0}}, 1'b1};
    return v & neg;
  endfunction

endpackage

// File: rtl/trip_chan_cmp.sv
module trip_chan_cmp #(
  parameter int unsigned SW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] sample,
  input  logic          valid,
  input  logic [SW-1:0] limit,
  output logic          over
);

  localparam logic [SW-1:0] MID = {1'b1, {(SW-1){1'b0}}};

  // distance of a unipolar code from the mid-scale zero level
  function automatic logic [SW-1:0] dist_from_mid(input logic [SW-1:0] s);
    if (s >= MID) return s - MID;
    else          return MID - s;
  endfunction

  logic over_now;
  assign over_now = dist_from_mid(sample) > limit;

  // the flag reflects the last valid sample, so a hazard stays present
  // until an in-limit conversion replaces it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     over <= 1'b0;
    else if (valid) over <= over_now;
  end

  p_ignore_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(over));

  p_valid_exceed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && over_now) |=> over);

endmodule

// File: rtl/trip_limit_bank.sv
module trip_limit_bank #(
  parameter int unsigned SW     = 12,
  parameter int unsigned N_CUR  = 4,
  parameter int unsigned N_VOLT = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [(N_CUR+N_VOLT)*SW-1:0] smp_data,
  input  logic                        smp_valid,
  input  logic [N_CUR*SW-1:0]         lim_cur,
  input  logic [N_VOLT*SW-1:0]        lim_volt,
  output logic                        cur_hazard,
  output logic                        volt_hazard
);

  localparam int unsigned N_CH = N_CUR + N_VOLT;

  logic [N_CH-1:0] over_vec;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic [SW-1:0] lim_i;
    if (i < N_CUR) begin : g_cur
      assign lim_i = lim_cur[i*SW +: SW];
    end else begin : g_volt
      assign lim_i = lim_volt[(i-N_CUR)*SW +: SW];
    end

    trip_chan_cmp #(.SW(SW)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .sample (smp_data[i*SW +: SW]),
      .valid  (smp_valid),
      .limit  (lim_i),
      .over   (over_vec[i])
    );
  end

  assign cur_hazard  = |over_vec[N_CUR-1:0];
  assign volt_hazard = |over_vec[N_CH-1:N_CUR];

endmodule

// File: rtl/trip_watchdog.sv
module trip_watchdog #(
  parameter int unsigned TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alive,
  input  logic [TW-1:0] timeout,
  output logic          expired
);

  logic          alive_q;
  logic          kick;
  logic [TW-1:0] cnt;

  assign kick    = alive ^ alive_q;
  assign expired = cnt >= timeout;

  // count cycles since the last level change, saturating once expired
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alive_q <= 1'b0;
      cnt     <= '0;
    end else begin
      alive_q <= alive;
      if (kick)          cnt <= '0;
      else if (!expired) cnt <= cnt + TW'(1);
    end
  end

  p_kick_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt == '0));

  p_hold_when_expired_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !kick && $stable(timeout)) |=> $stable(cnt));

endmodule

// File: rtl/trip_fault_latch.sv
module trip_fault_latch
  import trip_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FC_W-1:0] cause,
  input  logic            clear_req,
  output logic [FC_W-1:0] code,
  output logic            tripped,
  output logic            trip_nxt,
  output logic            clear_take
);

  logic [FC_W-1:0] code_nxt;
  logic            any_cause;

  assign any_cause  = |cause;
  assign clear_take = tripped && clear_req && !any_cause;

  always_comb begin
    code_nxt = code;
    trip_nxt = tripped;
    if (!tripped && any_cause) begin
      trip_nxt = 1'b1;
      code_nxt = lowest_cause(cause);
    end else if (clear_take) begin
      trip_nxt = 1'b0;
      code_nxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tripped <= 1'b0;
      code    <= '0;
    end else begin
      tripped <= trip_nxt;
      code    <= code_nxt;
    end
  end

  p_code_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(code));

  p_first_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && !clear_take) |=> $stable(code));

  p_cause_trips_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_cause |=> tripped);

  p_clear_only_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && any_cause) |=> tripped);

  p_clear_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear_take |=> (!tripped && code == '0));

endmodule

// File: rtl/conv_trip_guard.sv
module conv_trip_guard
  import trip_pkg::*;
#(
  parameter int unsigned SW     = 12,
  parameter int unsigned N_CUR  = 4,
  parameter int unsigned N_VOLT = 4,
  parameter int unsigned GATES  = 12,
  parameter int unsigned TW     = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [(N_CUR+N_VOLT)*SW-1:0] smp_data,
  input  logic                         smp_valid,
  input  logic [N_CUR*SW-1:0]          lim_cur,
  input  logic [N_VOLT*SW-1:0]         lim_volt,
  input  logic                         cpu_beat,
  input  logic                         host_alive,
  input  logic [TW-1:0]                cpu_timeout,
  input  logic [TW-1:0]                host_timeout,
  input  logic [GATES-1:0]             gate_req,
  input  logic                         clear_req,
  output logic [GATES-1:0]             gate_out,
  output logic [FC_W-1:0]              fault_code,
  output logic                         tripped
);

  logic            cur_hazard;
  logic            volt_hazard;
  logic            cpu_lost;
  logic            host_lost;
  logic [FC_W-1:0] cause;
  logic            trip_nxt;
  logic            clear_take;
  logic [GATES-1:0] gate_q;

  trip_limit_bank #(.SW(SW), .N_CUR(N_CUR), .N_VOLT(N_VOLT)) u_limits (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_data    (smp_data),
    .smp_valid   (smp_valid),
    .lim_cur     (lim_cur),
    .lim_volt    (lim_volt),
    .cur_hazard  (cur_hazard),
    .volt_hazard (volt_hazard)
  );

  trip_watchdog #(.TW(TW)) u_cpu_wd (
    .clk     (clk),
    .rst_n   (rst_n),
    .alive   (cpu_beat),
    .timeout (cpu_timeout),
    .expired (cpu_lost)
  );

  trip_watchdog #(.TW(TW)) u_host_wd (
    .clk     (clk),
    .rst_n   (rst_n),
    .alive   (host_alive),
    .timeout (host_timeout),
    .expired (host_lost)
  );

  always_comb begin
    cause          = '0;
    cause[FC_CUR]  = cur_hazard;
    cause[FC_VOLT] = volt_hazard;
    cause[FC_CPU]  = cpu_lost;
    cause[FC_HOST] = host_lost;
  end

  trip_fault_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .cause      (cause),
    .clear_req  (clear_req),
    .code       (fault_code),
    .tripped    (tripped),
    .trip_nxt   (trip_nxt),
    .clear_take (clear_take)
  );

  // every gate bit is its own register, forced to zero as one word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gate_q <= '0;
    else if (trip_nxt) gate_q <= '0;
    else               gate_q <= gate_req;
  end

  assign gate_out = gate_q;

  p_gates_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tripped |-> (gate_out == '0));

  p_clear_resumes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clear_take |=> (gate_out == $past(gate_req)));

endmodule

// File: tb/conv_trip_guard_test.sv
module conv_trip_guard_test;

  localparam int CPU_T  = 40;
  localparam int HOST_T = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] smp_data;
  logic        smp_valid = 1'b0;
  logic [47:0] lim_cur  = {4{12'd500}};
  logic [47:0] lim_volt = {4{12'd800}};
  logic        cpu_beat = 1'b0;
  logic        host_alive = 1'b0;
  logic [23:0] cpu_timeout  = 24'(CPU_T);
  logic [23:0] host_timeout = 24'(HOST_T);
  logic [11:0] gate_req = 12'hFFF;
  logic        clear_req = 1'b0;
  logic [11:0] gate_out;
  logic [3:0]  fault_code;
  logic        tripped;

  logic [11:0] ch [8];
  always_comb for (int i = 0; i < 8; i++) smp_data[i*12 +: 12] = ch[i];

  conv_trip_guard uut (
    .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
    .lim_cur(lim_cur), .lim_volt(lim_volt), .cpu_beat(cpu_beat),
    .host_alive(host_alive), .cpu_timeout(cpu_timeout),
    .host_timeout(host_timeout), .gate_req(gate_req), .clear_req(clear_req),
    .gate_out(gate_out), .fault_code(fault_code), .tripped(tripped)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          at;
    logic [11:0] g;
    logic [3:0]  c;
    logic        t;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit cpu_en = 1'b1;
  bit host_en = 1'b1;

  task automatic expect_at(input int d, input logic [11:0] g, input logic [3:0] c,
                           input logic t, input string tag);
    exp_t e;
    e.at = cyc + d; e.g = g; e.c = c; e.t = t; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: pops items whose cycle has come and compares them
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at == cyc) begin
      exp_t e;
      e = sb.pop_front();
      n_cmp++;
      if (gate_out !== e.g || fault_code !== e.c || tripped !== e.t) begin
        n_bad++;
        $display("FAIL %s: got gate=%h code=%b trip=%b, expected gate=%h code=%b trip=%b",
                 e.tag, gate_out, fault_code, tripped, e.g, e.c, e.t);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    if (cpu_en  && (cyc % 8 == 0)) cpu_beat   = ~cpu_beat;
    if (host_en && (cyc % 8 == 4)) host_alive = ~host_alive;
  endtask

  task automatic run(input int n);
    repeat (n) tick();
  endtask

  task automatic nominal();
    for (int i = 0; i < 8; i++) ch[i] = 12'd2048;
  endtask

  // one valid conversion; b < 0 leaves a single off-nominal channel
  task automatic pulse_sample(input int a, input logic [11:0] va,
                              input int b, input logic [11:0] vb);
    nominal();
    ch[a] = va;
    if (b >= 0) ch[b] = vb;
    smp_valid = 1'b1;
    tick();
    smp_valid = 1'b0;
  endtask

  task automatic clear_pulse();
    clear_req = 1'b1;
    tick();
    clear_req = 1'b0;
  endtask

  // replace channel hazards with an in-limit sample, then clear
  task automatic recover(input string tag);
    pulse_sample(0, 12'd2048, -1, 12'd0);
    expect_at(1, gate_req, 4'b0000, 1'b0, tag);
    clear_pulse();
    run(2);
  endtask

  initial begin
    nominal();
    // R1: outputs held at zero during reset
    run(2);
    expect_at(1, 12'h000, 4'b0000, 1'b0, "R1 reset state");
    run(3);
    rst_n = 1'b1;
    gate_req = 12'hA5C;
    expect_at(1, 12'hA5C, 4'b0000, 1'b0, "R2 pass-through first");
    tick();
    gate_req = 12'h3F1;
    expect_at(1, 12'h3F1, 4'b0000, 1'b0, "R2 pass-through second");
    run(3);

    // R5: out-of-limit word with valid low
    ch[0] = 12'd4000;
    ch[5] = 12'd0;
    for (int d = 1; d <= 3; d++) expect_at(d, 12'h3F1, 4'b0000, 1'b0, "R5 invalid ignored");
    run(4);

    // R3: deviation equal to the limit does not trip
    expect_at(2, 12'h3F1, 4'b0000, 1'b0, "R3 at limit");
    pulse_sample(0, 12'd2548, -1, 12'd0);
    run(3);

    // R3: one code beyond the limit trips, R8 gates off at once
    expect_at(1, 12'h3F1, 4'b0000, 1'b0, "R3 before trip");
    expect_at(2, 12'h000, 4'b0001, 1'b1, "R3 over-current trip / R8 gates off");
    pulse_sample(2, 12'd2549, -1, 12'd0);
    run(2);
    gate_req = 12'hFFF;
    expect_at(1, 12'h000, 4'b0001, 1'b1, "R8 request ignored while tripped");
    tick();
    // R9: later voltage cause leaves the code alone
    expect_at(2, 12'h000, 4'b0001, 1'b1, "R9 later cause kept out");
    pulse_sample(5, 12'd2849, -1, 12'd0);
    run(2);
    // R10: clear ignored while the channel hazard persists
    expect_at(1, 12'h000, 4'b0001, 1'b1, "R10 clear refused");
    clear_pulse();
    run(2);
    recover("R10 clear accepted");

    // R11: below mid-scale
    expect_at(2, 12'h000, 4'b0001, 1'b1, "R11 negative deviation");
    pulse_sample(1, 12'd1547, -1, 12'd0);
    run(2);
    recover("R10 clear after R11");

    // R4: over-voltage below mid-scale
    expect_at(1, 12'hFFF, 4'b0000, 1'b0, "R4 before trip");
    expect_at(2, 12'h000, 4'b0010, 1'b1, "R4 over-voltage trip");
    pulse_sample(6, 12'd1247, -1, 12'd0);
    run(2);
    recover("R10 clear after R4");

    // R9: simultaneous causes, full-scale codes at both ends
    expect_at(2, 12'h000, 4'b0001, 1'b1, "R9 simultaneous priority");
    pulse_sample(0, 12'd4095, 7, 12'd0);
    run(2);
    recover("R10 clear after R9");

    // R6: processor heartbeat stops after one known edge
    cpu_en = 1'b0;
    cpu_beat = ~cpu_beat;
    expect_at(CPU_T + 1, 12'hFFF, 4'b0000, 1'b0, "R6 one cycle before timeout");
    expect_at(CPU_T + 2, 12'h000, 4'b0100, 1'b1, "R6 processor watchdog trip");
    run(CPU_T + 3);
    expect_at(1, 12'h000, 4'b0100, 1'b1, "R10 clear refused while expired");
    clear_pulse();
    run(1);
    expect_at(2, 12'h000, 4'b0100, 1'b1, "R9 channel cause after watchdog");
    pulse_sample(3, 12'd100, -1, 12'd0);
    run(2);
    pulse_sample(0, 12'd2048, -1, 12'd0);
    cpu_beat = ~cpu_beat;
    cpu_en = 1'b1;
    tick();
    expect_at(1, 12'hFFF, 4'b0000, 1'b0, "R10 clear after heartbeat resumes");
    clear_pulse();
    run(3);

    // R7: host link lost
    host_en = 1'b0;
    host_alive = ~host_alive;
    expect_at(HOST_T + 1, 12'hFFF, 4'b0000, 1'b0, "R7 one cycle before timeout");
    expect_at(HOST_T + 2, 12'h000, 4'b1000, 1'b1, "R7 host watchdog trip");
    run(HOST_T + 3);
    host_alive = ~host_alive;
    host_en = 1'b1;
    tick();
    expect_at(1, 12'hFFF, 4'b0000, 1'b0, "R10 clear after host resumes");
    clear_pulse();
    run(4);

    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_cmp++;
      n_bad++;
      $display("FAIL %s: got no comparison, expected one at cycle %0d", e.tag, e.at);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule